// File: doc/BRIEF.md
# Keyboard controller command processor

This block is the host-facing side of a keyboard controller. A host presents one byte at a time with a port select: port 0 is the data port and port 1 is the command port. Command bytes are decoded at once. Some produce a reply byte, some change the mode or output-port register, some raise the system reset request, and five of them arm a pending state. The next data-port byte then becomes that command's argument. A data byte that arrives with nothing pending is passed to the keyboard byte stream.

Three byte streams leave the block, each through a one-entry valid/ready holding slot:
- replies, with a tag bit that marks each as keyboard (0) or auxiliary (1);
- keyboard bytes;
- mouse bytes.

A slot keeps its byte and tag unchanged until the sink accepts it. The host side stalls while any slot is occupied: `host_ready` is low whenever a byte waits in any of the three slots, so no byte is ever dropped or overwritten. The status register can be read at any time on a plain output. The A20 gate line and two single-cycle strobes are plain outputs: a system reset request, and a flag for unrecognised command bytes.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset the mode register is 0x03, status is 0x18, the output port is 0xCF, `a20` is 1, all three output streams are empty, `host_ready` is 1 and both strobes are low.
- R2: A write is taken on a clock edge where `host_valid` and `host_ready` are both high. Its effects appear from the next cycle. `host_ready` stays low while any output slot holds a byte. A held byte and its tag stay unchanged until `*_ready` is seen.
- R3: Command 0x20 replies with the current mode register, and command 0xD0 replies with the current output port. Both replies carry tag 0 (keyboard).
- R4: Command 0xAA sets status bit 2, which stays set until reset, and replies 0x55. Commands 0xA9 and 0xAB reply 0x00. Command 0xC0 replies 0x80.
- R5: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. None of these four commands gives a reply.
- R6: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only arm a pending argument and give no reply. Any data-port write clears the pending state. A data write with nothing pending goes out on the keyboard stream.
- R7: The argument byte is used according to the command that armed it. After 0x60 it becomes the mode register. After 0xD2 it is sent as a reply with tag 0, and after 0xD3 as a reply with tag 1. After 0xD4 it goes out on the mouse stream.
- R8: The argument after 0xD1 becomes the output port. `a20` takes its bit 1. If its bit 0 is 0, `sys_rst_req` pulses for one cycle in the same cycle that `a20` changes.
- R9: Command 0xDF sets output-port bit 1 and drives `a20` high. Command 0xDD clears the bit and drives `a20` low.
- R10: Every command whose upper nibble is 0xF is a pulse command. With bit 0 clear it pulses `sys_rst_req` for one cycle. With bit 0 set it does nothing. Neither form replies or flags an error.
- R11: Any other command byte leaves mode, status and the output port unchanged, gives no reply, and pulses `cmd_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host write strobe |
| host_ready | output | 1 | Block can take a host write |
| host_sel | input | 1 | 0 = data port, 1 = command port |
| host_data | input | 8 | Host write byte |
| status | output | 8 | Status register |
| rply_valid | output | 1 | Reply byte present |
| rply_ready | input | 1 | Reply sink accepts |
| rply_data | output | 8 | Reply byte |
| rply_aux | output | 1 | Reply tag, 1 = auxiliary |
| kbd_valid | output | 1 | Keyboard byte present |
| kbd_ready | input | 1 | Keyboard sink accepts |
| kbd_data | output | 8 | Byte for the keyboard |
| aux_valid | output | 1 | Mouse byte present |
| aux_ready | input | 1 | Mouse sink accepts |
| aux_data | output | 8 | Byte for the mouse |
| a20 | output | 1 | A20 gate level |
| sys_rst_req | output | 1 | One-cycle system reset request |
| cmd_err | output | 1 | One-cycle unknown-command flag |

## Verification
An output-port write with both low bits clear makes two things happen on the same clock edge: the A20 line falls and a reset request is strobed. The bench triggers this by sending 0xD1 followed by the argument 0x00. It records the level of `a20` at the edge where the reset strobe is seen, and expects it to be low. A second collision is a reply held under back-pressure while the host keeps offering a new command. Here the bench checks three things: the held byte stays the same, no extra reply appears once the sink is released, and the offered command is never taken.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // command codes
  localparam byte_t CMD_RD_MODE    = 8'h20;
  localparam byte_t CMD_WR_MODE    = 8'h60;
  localparam byte_t CMD_AUX_OFF    = 8'hA7;
  localparam byte_t CMD_AUX_ON     = 8'hA8;
  localparam byte_t CMD_AUX_TEST   = 8'hA9;
  localparam byte_t CMD_SELF_TEST  = 8'hAA;
  localparam byte_t CMD_KBD_TEST   = 8'hAB;
  localparam byte_t CMD_KBD_OFF    = 8'hAD;
  localparam byte_t CMD_KBD_ON     = 8'hAE;
  localparam byte_t CMD_RD_IN      = 8'hC0;
  localparam byte_t CMD_RD_OUT     = 8'hD0;
  localparam byte_t CMD_WR_OUT     = 8'hD1;
  localparam byte_t CMD_LOOP_KBD   = 8'hD2;
  localparam byte_t CMD_LOOP_AUX   = 8'hD3;
  localparam byte_t CMD_TO_AUX     = 8'hD4;
  localparam byte_t CMD_GATE_OFF   = 8'hDD;
  localparam byte_t CMD_GATE_ON    = 8'hDF;
  localparam byte_t CMD_PULSE_RST  = 8'hFE;
  localparam byte_t CMD_PULSE_NONE = 8'hFF;

  // fixed reply bytes
  localparam byte_t REP_TEST_OK    = 8'h55;
  localparam byte_t REP_LINK_OK    = 8'h00;
  localparam byte_t REP_IN_PORT    = 8'h80;

  // reset values
  localparam byte_t MODE_RST  = 8'h03;
  localparam byte_t STAT_RST  = 8'h18;
  localparam byte_t OPORT_RST = 8'hCF;

  // bit positions
  localparam int MODE_AUX_OFF_BIT = 5;
  localparam int MODE_KBD_OFF_BIT = 4;
  localparam int STAT_TEST_BIT    = 2;
  localparam int OP_GATE_BIT      = 1;
  localparam int OP_RUN_BIT       = 0;

  typedef struct packed {
    logic  reply;
    byte_t reply_byte;
    logic  arm;
    byte_t mode_set;
    byte_t mode_clr;
    logic  test_done;
    logic  gate_set;
    logic  gate_clr;
    logic  rst_req;
    logic  bad;
  } cmd_act_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  byte_t    cmd,
  input  byte_t    mode,
  input  byte_t    oport,
  output cmd_act_t act
);
  byte_t norm;

  // fold the pulse family onto its two meaningful forms
  always_comb begin
    norm = cmd;
    if (cmd[BYTE_W-1 -: 4] == 4'hF)
      norm = cmd[0] ? CMD_PULSE_NONE : CMD_PULSE_RST;
  end

  always_comb begin
    act = '0;
    case (norm)
      CMD_RD_MODE:   begin act.reply = 1'b1; act.reply_byte = mode;  end
      CMD_RD_OUT:    begin act.reply = 1'b1; act.reply_byte = oport; end
      CMD_AUX_TEST,
      CMD_KBD_TEST:  begin act.reply = 1'b1; act.reply_byte = REP_LINK_OK; end
      CMD_RD_IN:     begin act.reply = 1'b1; act.reply_byte = REP_IN_PORT; end
      CMD_SELF_TEST: begin
        act.reply = 1'b1; act.reply_byte = REP_TEST_OK; act.test_done = 1'b1;
      end
      CMD_WR_MODE, CMD_WR_OUT, CMD_LOOP_KBD, CMD_LOOP_AUX, CMD_TO_AUX:
                     act.arm = 1'b1;
      CMD_AUX_OFF:   act.mode_set[MODE_AUX_OFF_BIT] = 1'b1;
      CMD_AUX_ON:    act.mode_clr[MODE_AUX_OFF_BIT] = 1'b1;
      CMD_KBD_OFF:   act.mode_set[MODE_KBD_OFF_BIT] = 1'b1;
      CMD_KBD_ON:    act.mode_clr[MODE_KBD_OFF_BIT] = 1'b1;
      CMD_GATE_ON:   act.gate_set = 1'b1;
      CMD_GATE_OFF:  act.gate_clr = 1'b1;
      CMD_PULSE_RST: act.rst_req = 1'b1;
      CMD_PULSE_NONE: ;
      default:       act.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/kbc_hold_slot.sv
module kbc_hold_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));

  assert_no_overwrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid);
endmodule

// File: rtl/kbc_state_regs.sv
module kbc_state_regs
  import kbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  byte_t mode_set,
  input  byte_t mode_clr,
  input  logic  test_done,
  input  logic  gate_set,
  input  logic  gate_clr,
  input  logic  rst_req,
  input  logic  mode_wr,
  input  byte_t mode_wdata,
  input  logic  op_wr,
  input  byte_t op_wdata,
  output byte_t mode_q,
  output byte_t status_q,
  output byte_t oport_q,
  output logic  a20_q,
  output logic  sys_rst_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_RST;
      status_q  <= STAT_RST;
      oport_q   <= OPORT_RST;
      a20_q     <= OPORT_RST[OP_GATE_BIT];
      sys_rst_q <= 1'b0;
    end else begin
      if (mode_wr)
        mode_q <= mode_wdata;
      else if (fire)
        mode_q <= (mode_q | mode_set) & ~mode_clr;

      if (fire && test_done)
        status_q[STAT_TEST_BIT] <= 1'b1;

      if (op_wr) begin
        oport_q <= op_wdata;
        a20_q   <= op_wdata[OP_GATE_BIT];
      end else if (fire && gate_set) begin
        oport_q[OP_GATE_BIT] <= 1'b1;
        a20_q                <= 1'b1;
      end else if (fire && gate_clr) begin
        oport_q[OP_GATE_BIT] <= 1'b0;
        a20_q                <= 1'b0;
      end

      sys_rst_q <= (fire && rst_req) || (op_wr && !op_wdata[OP_RUN_BIT]);
    end
  end

  assert_a20_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    a20_q == oport_q[OP_GATE_BIT]);

  assert_selftest_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[STAT_TEST_BIT] |=> status_q[STAT_TEST_BIT]);
endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
  import kbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        host_sel,
  input  logic [7:0]  host_data,
  output logic [7:0]  status,
  output logic        rply_valid,
  input  logic        rply_ready,
  output logic [7:0]  rply_data,
  output logic        rply_aux,
  output logic        kbd_valid,
  input  logic        kbd_ready,
  output logic [7:0]  kbd_data,
  output logic        aux_valid,
  input  logic        aux_ready,
  output logic [7:0]  aux_data,
  output logic        a20,
  output logic        sys_rst_req,
  output logic        cmd_err
);
  localparam int RPLY_W = BYTE_W + 1;

  logic     acc, cmd_acc, dat_acc, arg_fire;
  logic     pend_v;
  byte_t    pend_code;
  cmd_act_t act;
  byte_t    mode_q, oport_q, status_q;
  logic     mode_wr, op_wr, loop_kbd, loop_aux, to_aux, kbd_load, rply_load;
  logic [RPLY_W-1:0] rply_din, rply_q;
  logic     err_q;

  assign host_ready = !rply_valid && !kbd_valid && !aux_valid;
  assign acc        = host_valid && host_ready;
  assign cmd_acc    = acc && host_sel;
  assign dat_acc    = acc && !host_sel;
  assign arg_fire   = dat_acc && pend_v;

  assign mode_wr  = arg_fire && (pend_code == CMD_WR_MODE);
  assign op_wr    = arg_fire && (pend_code == CMD_WR_OUT);
  assign loop_kbd = arg_fire && (pend_code == CMD_LOOP_KBD);
  assign loop_aux = arg_fire && (pend_code == CMD_LOOP_AUX);
  assign to_aux   = arg_fire && (pend_code == CMD_TO_AUX);
  assign kbd_load = dat_acc && !pend_v;

  kbc_cmd_decode u_dec (
    .cmd   (host_data),
    .mode  (mode_q),
    .oport (oport_q),
    .act   (act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_code <= '0;
      err_q     <= 1'b0;
    end else begin
      if (dat_acc)
        pend_v <= 1'b0;
      else if (cmd_acc && act.arm) begin
        pend_v    <= 1'b1;
        pend_code <= host_data;
      end
      err_q <= cmd_acc && act.bad;
    end
  end

  kbc_state_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (cmd_acc),
    .mode_set   (act.mode_set),
    .mode_clr   (act.mode_clr),
    .test_done  (act.test_done),
    .gate_set   (act.gate_set),
    .gate_clr   (act.gate_clr),
    .rst_req    (act.rst_req),
    .mode_wr    (mode_wr),
    .mode_wdata (host_data),
    .op_wr      (op_wr),
    .op_wdata   (host_data),
    .mode_q     (mode_q),
    .status_q   (status_q),
    .oport_q    (oport_q),
    .a20_q      (a20),
    .sys_rst_q  (sys_rst_req)
  );

  assign rply_load = (cmd_acc && act.reply) || loop_kbd || loop_aux;
  always_comb begin
    if (loop_kbd)      rply_din = {1'b0, host_data};
    else if (loop_aux) rply_din = {1'b1, host_data};
    else               rply_din = {1'b0, act.reply_byte};
  end

  kbc_hold_slot #(.W(RPLY_W)) u_rply (
    .clk(clk), .rst_n(rst_n), .load(rply_load), .din(rply_din),
    .ready(rply_ready), .valid(rply_valid), .dout(rply_q)
  );
  assign rply_aux  = rply_q[BYTE_W];
  assign rply_data = rply_q[BYTE_W-1:0];

  kbc_hold_slot #(.W(BYTE_W)) u_kbd (
    .clk(clk), .rst_n(rst_n), .load(kbd_load), .din(host_data),
    .ready(kbd_ready), .valid(kbd_valid), .dout(kbd_data)
  );

  kbc_hold_slot #(.W(BYTE_W)) u_aux (
    .clk(clk), .rst_n(rst_n), .load(to_aux), .din(host_data),
    .ready(aux_ready), .valid(aux_valid), .dout(aux_data)
  );

  assign status  = status_q;
  assign cmd_err = err_q;

  assert_bad_cmd_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($stable(mode_q) && $stable(oport_q) && $stable(status_q) && !rply_valid));

  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_acc |=> !pend_v);

  assert_one_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rply_load, kbd_load, to_aux}) <= 1);
endmodule

// File: tb/tb_kbc_cmd_proc.sv
module tb_kbc_cmd_proc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0, host_sel = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       host_ready;
  logic [7:0] status;
  logic       rply_valid, rply_aux, kbd_valid, aux_valid;
  logic       rply_ready = 1'b1, kbd_ready = 1'b1, aux_ready = 1'b1;
  logic [7:0] rply_data, kbd_data, aux_data;
  logic       a20, sys_rst_req, cmd_err;

  int checks = 0, errors = 0;
  int rep_cnt = 0, kbd_cnt = 0, aux_cnt = 0, err_cnt = 0, rst_cnt = 0;
  logic [7:0] rep_last, kbd_last, aux_last;
  logic rep_last_aux, rst_a20;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbc_cmd_proc dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_sel(host_sel), .host_data(host_data), .status(status),
    .rply_valid(rply_valid), .rply_ready(rply_ready), .rply_data(rply_data),
    .rply_aux(rply_aux), .kbd_valid(kbd_valid), .kbd_ready(kbd_ready),
    .kbd_data(kbd_data), .aux_valid(aux_valid), .aux_ready(aux_ready),
    .aux_data(aux_data), .a20(a20), .sys_rst_req(sys_rst_req), .cmd_err(cmd_err)
  );

  // handshake / strobe monitor
  always @(posedge clk) begin
    if (rply_valid && rply_ready) begin
      rep_cnt++; rep_last = rply_data; rep_last_aux = rply_aux;
    end
    if (kbd_valid && kbd_ready) begin kbd_cnt++; kbd_last = kbd_data; end
    if (aux_valid && aux_ready) begin aux_cnt++; aux_last = aux_data; end
    if (cmd_err) err_cnt++;
    if (sys_rst_req) begin rst_cnt++; rst_a20 = a20; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1; host_sel = sel; host_data = d;
    @(negedge clk);
    host_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit known(input logic [7:0] c);
    if (c[7:4] == 4'hF) return 1;
    case (c)
      8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE,
      8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF: return 1;
      default: return 0;
    endcase
  endfunction

  // {has_reply, byte} after reset
  function automatic logic [8:0] exp_rep(input logic [7:0] c);
    case (c)
      8'h20: return {1'b1, 8'h03};
      8'hD0: return {1'b1, 8'hCF};
      8'hA9, 8'hAB: return {1'b1, 8'h00};
      8'hAA: return {1'b1, 8'h55};
      8'hC0: return {1'b1, 8'h80};
      default: return 9'h000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0, k0, a0, e0, r0;
    do_reset();
    // R1 reset state
    chk("R1 status", status, 8'h18);
    chk("R1 host_ready", host_ready, 1);
    chk("R1 a20", a20, 1);
    chk("R1 valids", {rply_valid, kbd_valid, aux_valid}, 0);
    chk("R1 strobes", {sys_rst_req, cmd_err}, 0);
    p0 = rep_cnt; wr(1, 8'h20);
    chk("R1 mode", rep_last, 8'h03);
    wr(1, 8'hD0);
    chk("R1 oport", rep_last, 8'hCF);
    chk("R3 reply tag", rep_last_aux, 0);
    chk("R3 reply count", rep_cnt, p0 + 2);

    // sweep of every command byte from reset
    for (int i = 0; i < 256; i++) begin
      logic [7:0] c, em, eo, es;
      logic [8:0] er;
      string rq;
      c = i[7:0];
      do_reset();
      e0 = err_cnt; r0 = rst_cnt; p0 = rep_cnt;
      wr(1, c);
      rq = (c[7:4] == 4'hF) ? "R10" : (known(c) ? "R3" : "R11");
      chk({rq, " err strobe"}, err_cnt - e0, known(c) ? 0 : 1);
      chk({rq, " reset strobe"}, rst_cnt - r0, (c[7:4] == 4'hF && !c[0]) ? 1 : 0);
      er = exp_rep(c);
      chk({rq, " reply count"}, rep_cnt - p0, er[8] ? 1 : 0);
      if (er[8]) chk("R4 reply byte", rep_last, er[7:0]);
      em = 8'h03;
      if (c == 8'hA7) em = 8'h23;
      if (c == 8'hAD) em = 8'h13;
      eo = (c == 8'hDD) ? 8'hCD : 8'hCF;
      es = (c == 8'hAA) ? 8'h1C : 8'h18;
      wr(1, 8'h20);
      chk("R5 mode after cmd", rep_last, em);
      wr(1, 8'hD0);
      chk("R9 oport after cmd", rep_last, eo);
      chk("R9 a20 after cmd", a20, eo[1]);
      chk("R4 status after cmd", status, es);
    end

    // R5 set then clear
    do_reset();
    wr(1, 8'hA7); wr(1, 8'hAD); wr(1, 8'h20);
    chk("R5 both set", rep_last, 8'h33);
    wr(1, 8'hA8); wr(1, 8'h20);
    chk("R5 aux cleared", rep_last, 8'h13);
    wr(1, 8'hAE); wr(1, 8'h20);
    chk("R5 kbd cleared", rep_last, 8'h03);

    // R6 plain data / R7 arguments
    do_reset();
    k0 = kbd_cnt; wr(0, 8'h5A);
    chk("R6 kbd count", kbd_cnt - k0, 1);
    chk("R6 kbd byte", kbd_last, 8'h5A);
    p0 = rep_cnt; wr(1, 8'h60);
    chk("R6 arm no reply", rep_cnt - p0, 0);
    k0 = kbd_cnt; wr(0, 8'h47);
    chk("R6 arg not to kbd", kbd_cnt - k0, 0);
    wr(1, 8'h20);
    chk("R7 mode loaded", rep_last, 8'h47);
    p0 = rep_cnt; wr(1, 8'hD2); wr(0, 8'h33);
    chk("R7 kbd loop count", rep_cnt - p0, 1);
    chk("R7 kbd loop byte", rep_last, 8'h33);
    chk("R7 kbd loop tag", rep_last_aux, 0);
    k0 = kbd_cnt; wr(0, 8'h77);
    chk("R6 pending cleared", kbd_cnt - k0, 1);
    chk("R6 pending cleared byte", kbd_last, 8'h77);
    wr(1, 8'hD3); wr(0, 8'h44);
    chk("R7 aux loop byte", rep_last, 8'h44);
    chk("R7 aux loop tag", rep_last_aux, 1);
    a0 = aux_cnt; k0 = kbd_cnt; wr(1, 8'hD4); wr(0, 8'h66);
    chk("R7 mouse count", aux_cnt - a0, 1);
    chk("R7 mouse byte", aux_last, 8'h66);
    chk("R7 mouse not kbd", kbd_cnt - k0, 0);

    // R8 output port writes
    do_reset();
    r0 = rst_cnt; wr(1, 8'hD1); wr(0, 8'hCD);
    chk("R8 a20 low", a20, 0);
    chk("R8 no reset", rst_cnt - r0, 0);
    wr(1, 8'hD0);
    chk("R8 oport readback", rep_last, 8'hCD);
    wr(1, 8'hD1); wr(0, 8'h02);
    chk("R8 a20 high", a20, 1);
    chk("R8 reset pulse", rst_cnt - r0, 1);
    // same-cycle: A20 falls while reset pulses
    wr(1, 8'hD1); wr(0, 8'h00);
    chk("R8 reset pulse 2", rst_cnt - r0, 2);
    chk("R8 a20 at reset", rst_a20, 0);
    wr(1, 8'hDF);
    chk("R9 gate on", a20, 1);
    wr(1, 8'hD0);
    chk("R9 oport bit1", rep_last, 8'h02);

    // R2 back-pressure
    do_reset();
    rply_ready = 1'b0;
    p0 = rep_cnt;
    wr(1, 8'hAA);
    chk("R2 ready low", host_ready, 0);
    chk("R2 held valid", rply_valid, 1);
    host_valid = 1'b1; host_sel = 1'b1; host_data = 8'hC0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R2 held byte", rply_data, 8'h55);
      chk("R2 no handshake", rep_cnt - p0, 0);
    end
    host_valid = 1'b0;
    rply_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 released count", rep_cnt - p0, 1);
    chk("R2 released byte", rep_last, 8'h55);
    chk("R2 ready back", host_ready, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule